// File: doc/BRIEF.md
# Single-Transfer Processor Bus Cycle Engine

This block turns one read or write request at a time from an internal requester into a single external bus transfer. Each transfer starts with an address clock and continues with one or more data clocks. In the address clock the block pulls its address strobe low and puts the word address, the active-low byte enables and three qualifiers on the bus. The qualifiers are memory/IO, data/control and write/read. In every data clock the block holds its last-transfer flag low. This marks the transfer as a single one.

The external system ends a transfer by pulling the active-low ready input low at the end of a data clock. While ready stays high, the block repeats the data clock, and each repeat is one wait state. Ready is not looked at during the address clock. When the transfer ends, the block returns a one-clock done pulse to the requester. For a read, it also returns the captured data. The requester may present its next request in the clock where the current transfer ends, so two-clock transfers can run back to back.

Top module: `nbus_master`

## Requirements
- R1: After reset the bus is idle: `ads_n`=1, `blast_n`=1, `data_oe`=0, `done`=0 and `req_ready`=1.
- R2: A request accepted at a clock edge (`req_valid`=1 while `req_ready`=1) makes the next clock an address clock. In that clock `ads_n` is 0 for exactly one clock, `addr_out` equals `req_addr`, `be_n` equals the bitwise inverse of `req_be`, and `mio`, `dc` and `wr` equal `req_mem`, `req_data`, `req_write` (1 = memory, data, write).
- R3: The value of `rdy_n` at the end of the address clock is ignored. A data clock always follows the address clock.
- R4: A transfer with `rdy_n`=0 at the end of its first data clock lasts exactly two clocks. `done` is 1 for exactly the one clock after that edge.
- R5: While `rdy_n`=1 at the end of a data clock, the data clock repeats. N wait states give a transfer of 2+N clocks.
- R6: `blast_n` is 0 in every data clock and 1 in address and idle clocks.
- R7: On a read, `bus_din` is captured at the edge where ready is sampled low. It appears on `rd_data` while `done` is 1 and is held until the next read completes.
- R8: `data_oe` is 1 only in data clocks of a write. While it is 1, `data_out` carries the write data. While it is 0, `data_out` is 0.
- R9: `addr_out`, `be_n`, `mio`, `dc` and `wr` stay stable from the address clock until the transfer completes.
- R10: A request presented in the data clock where ready is low is accepted (`req_ready`=1). Its address clock follows in the very next clock, with no idle clock between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = IO space |
| req_data | input | 1 | 1 = data transfer, 0 = control transfer |
| req_addr | input | ADDR_W (30) | Word address |
| req_be | input | BE_W (4) | Active-high byte enables |
| req_wdata | input | DATA_W (32) | Write data |
| req_ready | output | 1 | Request accepted at this edge if valid |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W (32) | Captured read data |
| ads_n | output | 1 | Active-low address strobe |
| addr_out | output | ADDR_W (30) | Word address on the bus |
| be_n | output | BE_W (4) | Active-low byte enables |
| mio | output | 1 | Memory/IO qualifier |
| dc | output | 1 | Data/control qualifier |
| wr | output | 1 | Write/read qualifier |
| blast_n | output | 1 | Active-low last-transfer flag |
| rdy_n | input | 1 | Active-low ready from the system |
| bus_din | input | DATA_W (32) | Data from the system |
| data_out | output | DATA_W (32) | Write data to the system |
| data_oe | output | 1 | Write data drive enable |

## Verification
The bench holds ready low during the address clock. A design that honoured ready there would end the transfer after one clock and would never show a data clock. Transfers are run with zero, one and several wait states. The bench checks that the last-transfer flag, the address and the write data stay put through every repeated data clock. A design that dropped a wait state would pulse done early and return stale read data. A back-to-back pair checks that the second address strobe arrives in the clock right after completion. A design that forced an idle clock, or lost the request presented in the final data clock, would show the strobe late or never.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } nbus_state_e;
endpackage

// File: rtl/nbus_seq.sv
module nbus_seq
   import nbus_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        rdy_n,
   output nbus_state_e state,
   output logic        load,
   output logic        finish
);
   nbus_state_e nxt;

   // ready is only meaningful in a data clock
   assign finish = (state == ST_DATA) && !rdy_n;
   assign load   = req_valid && ((state == ST_IDLE) || finish);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: nxt = load ? ST_ADDR : ST_IDLE;
         ST_ADDR: nxt = ST_DATA;
         ST_DATA: begin
            if (finish) nxt = load ? ST_ADDR : ST_IDLE;
            else        nxt = ST_DATA;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/nbus_req_latch.sv
module nbus_req_latch #(
   parameter int ADDR_W = 30,
   parameter int DATA_W = 32,
   parameter int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              in_write,
   input  logic              in_mem,
   input  logic              in_data,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [BE_W-1:0]   in_be,
   input  logic [DATA_W-1:0] in_wdata,
   output logic              q_write,
   output logic              q_mem,
   output logic              q_data,
   output logic [ADDR_W-1:0] q_addr,
   output logic [BE_W-1:0]   q_be_n,
   output logic [DATA_W-1:0] q_wdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_write <= 1'b0;
         q_mem   <= 1'b0;
         q_data  <= 1'b0;
         q_addr  <= '0;
         q_be_n  <= '1;
         q_wdata <= '0;
      end else if (load) begin
         q_write <= in_write;
         q_mem   <= in_mem;
         q_data  <= in_data;
         q_addr  <= in_addr;
         q_be_n  <= ~in_be;
         q_wdata <= in_wdata;
      end
   end
endmodule

// File: rtl/nbus_rd_capture.sv
module nbus_rd_capture #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              finish,
   input  logic              is_write,
   input  logic [DATA_W-1:0] bus_din,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= finish;
         if (finish && !is_write) rd_data <= bus_din;
      end
   end
endmodule

// File: rtl/nbus_master.sv
module nbus_master
   import nbus_pkg::*;
#(
   parameter int ADDR_W      = 30,
   parameter int DATA_W      = 32,
   parameter int BE_W        = DATA_W / 8,
   parameter bit GATE_WDATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_mem,
   input  logic              req_data,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              ads_n,
   output logic [ADDR_W-1:0] addr_out,
   output logic [BE_W-1:0]   be_n,
   output logic              mio,
   output logic              dc,
   output logic              wr,
   output logic              blast_n,
   input  logic              rdy_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe
);
   localparam int BYTES = DATA_W / 8;

   initial begin
      assert (DATA_W % 8 == 0 && DATA_W >= 8)
         else $error("DATA_W must be a whole number of bytes");
      assert (BE_W == BYTES)
         else $error("BE_W must equal DATA_W/8");
      assert (ADDR_W >= 1)
         else $error("ADDR_W must be positive");
   end

   nbus_state_e state;
   logic        load, finish;
   logic [DATA_W-1:0] wdata_q;

   nbus_seq u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rdy_n(rdy_n),
      .state(state), .load(load), .finish(finish)
   );

   nbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .load(load),
      .in_write(req_write), .in_mem(req_mem), .in_data(req_data),
      .in_addr(req_addr), .in_be(req_be), .in_wdata(req_wdata),
      .q_write(wr), .q_mem(mio), .q_data(dc),
      .q_addr(addr_out), .q_be_n(be_n), .q_wdata(wdata_q)
   );

   nbus_rd_capture #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .finish(finish), .is_write(wr),
      .bus_din(bus_din), .done(done), .rd_data(rd_data)
   );

   assign req_ready = (state == ST_IDLE) || finish;
   assign ads_n     = (state != ST_ADDR);
   assign blast_n   = (state != ST_DATA);
   assign data_oe   = (state == ST_DATA) && wr;

   generate
      if (GATE_WDATA) begin : g_gate
         assign data_out = data_oe ? wdata_q : '0;
      end else begin : g_hold
         assign data_out = wdata_q;
      end
   endgenerate
endmodule

// File: rtl/nbus_master_chk.sv
module nbus_master_chk #(
   parameter int ADDR_W = 30,
   parameter int BE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ads_n,
   input logic              blast_n,
   input logic              rdy_n,
   input logic              done,
   input logic              wr,
   input logic              mio,
   input logic              dc,
   input logic              data_oe,
   input logic [ADDR_W-1:0] addr_out,
   input logic [BE_W-1:0]   be_n
);
   assert_strobe_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |=> ads_n);

   assert_addr_ignores_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |=> !blast_n);

   assert_done_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!blast_n && !rdy_n) |=> done);

   assert_wait_repeats_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!blast_n && rdy_n) |=> (!blast_n && !done));

   assert_strobe_flag_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ads_n && !blast_n));

   assert_oe_write_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!blast_n && wr));

   assert_qual_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !blast_n |-> ($stable(addr_out) && $stable(be_n) && $stable(wr)
                    && $stable(mio) && $stable(dc)));
endmodule

bind nbus_master nbus_master_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .blast_n(blast_n), .rdy_n(rdy_n),
   .done(done), .wr(wr), .mio(mio), .dc(dc), .data_oe(data_oe),
   .addr_out(addr_out), .be_n(be_n)
);

// File: tb/nbus_master_tb.sv
module nbus_master_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_data = 1'b0;
   logic [29:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, done, ads_n, mio, dc, wr, blast_n, data_oe;
   logic [31:0] rd_data, data_out;
   logic [29:0] addr_out;
   logic [3:0]  be_n;
   logic        rdy_n = 1'b1;
   logic [31:0] bus_din = '0;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nbus_master u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mem(req_mem), .req_data(req_data), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rd_data(rd_data),
      .ads_n(ads_n), .addr_out(addr_out), .be_n(be_n), .mio(mio), .dc(dc), .wr(wr),
      .blast_n(blast_n), .rdy_n(rdy_n), .bus_din(bus_din), .data_out(data_out),
      .data_oe(data_oe)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_req(input bit w, input bit m, input bit d, input logic [29:0] a,
                          input logic [3:0] be, input logic [31:0] wd);
      req_valid = 1'b1; req_write = w; req_mem = m; req_data = d;
      req_addr = a; req_be = be; req_wdata = wd;
   endtask

   task automatic check_addr_clk(input bit w, input bit m, input bit d,
                                 input logic [29:0] a, input logic [3:0] be);
      check(ads_n == 1'b0, "R2 strobe", 64'(ads_n), 64'd0);
      check(blast_n == 1'b1, "R6 flag in address clock", 64'(blast_n), 64'd1);
      check(addr_out == a, "R2 address", 64'(addr_out), 64'(a));
      check(be_n == ~be, "R2 byte enables", 64'(be_n), 64'(~be));
      check({mio, dc, wr} == {m, d, w}, "R2 qualifiers", 64'({mio, dc, wr}), 64'({m, d, w}));
   endtask

   // one transfer; waits = number of wait states; t1_rdy drives ready low in the address clock
   task automatic run_cycle(input bit w, input logic [29:0] a, input logic [3:0] be,
                            input logic [31:0] d, input int waits, input bit t1_rdy);
      set_req(w, 1'b1, 1'b1, a, be, d);
      @(negedge clk);
      req_valid = 1'b0;
      check_addr_clk(w, 1'b1, 1'b1, a, be);
      rdy_n = t1_rdy ? 1'b0 : 1'b1;
      for (int i = 0; i <= waits; i++) begin
         @(negedge clk);
         check(!blast_n && ads_n, i == 0 ? "R3 data clock after address clock"
                                         : "R5 wait state repeats data clock",
               64'({ads_n, blast_n}), 64'b10);
         check(done == 1'b0, "R5 no early done", 64'(done), 64'd0);
         check(addr_out == a && be_n == ~be, "R9 stable address", 64'(addr_out), 64'(a));
         check(data_oe == w, "R8 drive enable", 64'(data_oe), 64'(w));
         check(data_out == (w ? d : 32'd0), "R8 data out", 64'(data_out),
               64'(w ? d : 32'd0));
         rdy_n   = (i == waits) ? 1'b0 : 1'b1;
         bus_din = (i == waits) ? d : ~d;
      end
      @(negedge clk);
      rdy_n = 1'b1; bus_din = '0;
      check(done == 1'b1, "R4 done pulse", 64'(done), 64'd1);
      check(blast_n && ads_n && !data_oe, "R6 idle after transfer",
            64'({ads_n, blast_n, data_oe}), 64'b110);
      if (!w) check(rd_data == d, "R7 read data", 64'(rd_data), 64'(d));
      @(negedge clk);
      check(done == 1'b0, "R4 done one clock", 64'(done), 64'd0);
      if (!w) check(rd_data == d, "R7 read data held", 64'(rd_data), 64'(d));
   endtask

   task automatic test_reset;
      check(ads_n && blast_n && !data_oe && !done && req_ready, "R1 reset state",
            64'({ads_n, blast_n, data_oe, done, req_ready}), 64'b11001);
   endtask

   task automatic test_back_to_back;
      set_req(1'b0, 1'b0, 1'b0, 30'h0000_0AB, 4'b0011, 32'h0);
      @(negedge clk);
      check_addr_clk(1'b0, 1'b0, 1'b0, 30'h0000_0AB, 4'b0011);
      req_valid = 1'b0; rdy_n = 1'b0;
      @(negedge clk);
      check(!blast_n, "R6 flag low in data clock", 64'(blast_n), 64'd0);
      check(req_ready == 1'b1, "R10 accepting during completion", 64'(req_ready), 64'd1);
      bus_din = 32'h5A5A_1234;
      set_req(1'b1, 1'b1, 1'b0, 30'h3FFF_FFC, 4'b1100, 32'hCAFE_F00D);
      @(negedge clk);
      req_valid = 1'b0;
      check(done == 1'b1, "R10 first done", 64'(done), 64'd1);
      check(rd_data == 32'h5A5A_1234, "R7 first read data", 64'(rd_data), 64'h5A5A_1234);
      check(ads_n == 1'b0, "R10 next strobe without idle", 64'(ads_n), 64'd0);
      check_addr_clk(1'b1, 1'b1, 1'b0, 30'h3FFF_FFC, 4'b1100);
      @(negedge clk);
      check(data_oe && data_out == 32'hCAFE_F00D, "R8 second write data",
            64'(data_out), 64'hCAFE_F00D);
      @(negedge clk);
      rdy_n = 1'b1;
      check(done == 1'b1, "R4 second done", 64'(done), 64'd1);
      check(rd_data == 32'h5A5A_1234, "R7 held across write", 64'(rd_data), 64'h5A5A_1234);
      @(negedge clk);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_cycle(1'b0, 30'h0001_234, 4'b1111, 32'h1122_3344, 0, 1'b0);
      run_cycle(1'b1, 30'h0002_000, 4'b0001, 32'hDEAD_BEEF, 0, 1'b0);
      run_cycle(1'b1, 30'h0003_111, 4'b0110, 32'h0BAD_C0DE, 1, 1'b0);
      run_cycle(1'b0, 30'h1555_555, 4'b1000, 32'h8765_4321, 4, 1'b0);
      run_cycle(1'b0, 30'h2AAA_AAA, 4'b0101, 32'h0F0F_F0F0, 0, 1'b1);
      run_cycle(1'b1, 30'h0000_001, 4'b1010, 32'h1357_9BDF, 2, 1'b1);
      test_back_to_back();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule